// File: doc/BRIEF.md
# Multi-Gate Interrupt Pending Aggregator

This block collects a set of level-sensitive interrupt lines and decides which of them may disturb the processor. Each line can be governed by several independent enable bits. These bits might sit in a mask register, a priority field or a group enable, all held elsewhere. The neighbouring logic does not tell the block the value of each bit. It sends a one-cycle strobe whenever a governing bit is switched on or off. The block keeps, per source, a count of how many of its governing bits are on. It treats the source as enabled only when that count reaches the source's configured number of governors.

A source is pending when its line is high and it is enabled. A running total of pending sources is kept. A single request line goes to the processor while that total is non-zero. A lookup path takes the processor's current 4-bit mask level and produces a registered vector with a valid flag. The vector belongs to the lowest-indexed pending source. The flag is withheld entirely when the mask level is at its ceiling of 15.

Per-source vectors are derived from a base plus a stride times the source index. The governor counts come from a packed configuration parameter, two bits per source.

Top module: `irq_gate_agg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `irq_req` and `vec_valid` are 0 and every enable count is zero.
- R2: A source line is sampled every cycle, and only a change of its level alters its state; holding a line at the same level for any number of cycles changes no output.
- R3: A one-cycle pulse on `en_up[i]` raises source i's enable count by one and a pulse on `en_dn[i]` lowers it by one; both high in the same cycle leave the count unchanged; source i is enabled only while its count equals its configured governor count `MAX_CFG[2*i +: 2]`.
- R4: An up pulse with the count already at 3, and a down pulse with the count at 0, are ignored.
- R5: Source i is pending exactly when its line is high and it is enabled; a source configured with zero governors becomes pending on its line alone.
- R6: `irq_req` is high while at least one source is pending: it rises when the first source becomes pending, holds while others remain, and falls only when the last one clears.
- R7: When `mask_lvl` is 4'hF, `vec_valid` is 0 on the next cycle regardless of pending sources.
- R8: Otherwise `vec_valid` is 1 when any source is pending, and `vec_out` is `VEC_BASE + i*VEC_STEP` for the lowest index i that is pending.
- R9: `irq_req` responds on the first clock edge after a line change, and `vec_valid`/`vec_out` follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt lines, one per source |
| en_up | input | NUM_SRC | Strobe: one governing enable of the source was turned on |
| en_dn | input | NUM_SRC | Strobe: one governing enable of the source was turned off |
| mask_lvl | input | 4 | Processor's current interrupt mask level |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | The vector output names a serviceable source |
| vec_out | output | VEC_W | Vector of the lowest-indexed pending source |

## Verification
The lookup is tried in four situations. In the first, only one source is pending. In the second, a lower and a higher index are pending together, which shows that the lowest index wins. In the third, the lower source drops while the higher one stays, so the request must hold and the vector must move. In the fourth, the mask sits at its ceiling while sources are still pending, which separates the request line from the valid flag.

Enable counting is tested on sources with zero, one, two and three governors. Simultaneous up and down strobes are applied. Extra strobes are pushed past both ends of the count. A wrapping counter would then leave a source enabled at the wrong moment. Repeated identical levels and a cycle-exact latency sequence tell a level-follower apart from a design that reacts to every sample.

// File: rtl/irq_gate_agg_pkg.sv
package irq_gate_agg_pkg;

    localparam int MAX_SRC  = 32;
    localparam int VEC_W    = 12;
    localparam int ECNT_W   = 2;
    localparam int MASK_W   = 4;
    localparam logic [MASK_W-1:0] MASK_CEIL = '1;
    localparam logic [ECNT_W-1:0] ECNT_TOP  = '1;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } vec_sel_t;

    // Default governor counts: source i is governed by (i mod 4) enables.
    function automatic logic [ECNT_W*MAX_SRC-1:0] build_max_cfg();
        logic [ECNT_W*MAX_SRC-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_SRC; i++) begin
            r[ECNT_W*i +: ECNT_W] = ECNT_W'(i % 4);
        end
        return r;
    endfunction

    localparam logic [ECNT_W*MAX_SRC-1:0] DEFAULT_MAX_CFG = build_max_cfg();

endpackage

// File: rtl/igq_src_track.sv
module igq_src_track
    import irq_gate_agg_pkg::*;
#(
    parameter logic [ECNT_W-1:0] GOV_CNT = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic en_up,
    input  logic en_dn,
    output logic pend_q,
    output logic rise,
    output logic fall
);

    logic              lvl_q;
    logic [ECNT_W-1:0] cnt_q;
    logic [ECNT_W-1:0] cnt_d;
    logic              pend_d;

    always_comb begin
        cnt_d = cnt_q;
        if (en_up && !en_dn && cnt_q != ECNT_TOP) begin
            cnt_d = cnt_q + 1'b1;
        end else if (en_dn && !en_up && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign pend_d = lvl && (cnt_d == GOV_CNT);
    assign rise   = pend_d && !pend_q;
    assign fall   = !pend_d && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            lvl_q  <= lvl;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    // R2
    hold_level_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl == lvl_q && !en_up && !en_dn) |=> $stable(pend_q));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (en_up && !en_dn && cnt_q != ECNT_TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        (en_up && cnt_q == ECNT_TOP) |=> (cnt_q == ECNT_TOP));

    // R4
    sat_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (en_dn && cnt_q == '0) |=> (cnt_q == '0));

    // R5
    pend_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> lvl_q);

endmodule

// File: rtl/igq_pend_count.sv
module igq_pend_count
    import irq_gate_agg_pkg::*;
#(
    parameter int NUM_SRC = MAX_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] rise_vec,
    input  logic [NUM_SRC-1:0] fall_vec,
    output logic [$clog2(NUM_SRC+1)-1:0] pend_cnt,
    output logic               irq_req
);

    localparam int CW = $clog2(NUM_SRC + 1);

    logic [CW-1:0] up_n;
    logic [CW-1:0] dn_n;
    logic [CW-1:0] cnt_d;

    assign up_n  = CW'($countones(rise_vec));
    assign dn_n  = CW'($countones(fall_vec));
    assign cnt_d = pend_cnt + up_n - dn_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt <= '0;
            irq_req  <= 1'b0;
        end else begin
            pend_cnt <= cnt_d;
            irq_req  <= (cnt_d != '0);
        end
    end

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_cnt == '0) |-> (dn_n == '0));

endmodule

// File: rtl/igq_vec_pick.sv
module igq_vec_pick
    import irq_gate_agg_pkg::*;
#(
    parameter int               NUM_SRC  = MAX_SRC,
    parameter logic [VEC_W-1:0] VEC_BASE = 12'h200,
    parameter logic [VEC_W-1:0] VEC_STEP = 12'h020
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_vec,
    input  logic [MASK_W-1:0]  mask_lvl,
    output vec_sel_t           sel_q
);

    vec_sel_t sel_d;

    always_comb begin
        sel_d = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_vec[i]) begin
                sel_d.valid = 1'b1;
                sel_d.vec   = VEC_BASE + VEC_W'(i) * VEC_STEP;
            end
        end
        if (mask_lvl == MASK_CEIL) begin
            sel_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    // R7
    mask_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_lvl == MASK_CEIL) |=> !sel_q.valid);

    // R8
    any_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vec != '0 && mask_lvl != MASK_CEIL) |=> sel_q.valid);

    // R8
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vec[0] && mask_lvl != MASK_CEIL) |=> (sel_q.vec == VEC_BASE));

endmodule

// File: rtl/irq_gate_agg.sv
module irq_gate_agg
    import irq_gate_agg_pkg::*;
#(
    parameter int                         NUM_SRC  = MAX_SRC,
    parameter logic [VEC_W-1:0]           VEC_BASE = 12'h200,
    parameter logic [VEC_W-1:0]           VEC_STEP = 12'h020,
    parameter logic [ECNT_W*MAX_SRC-1:0]  MAX_CFG  = DEFAULT_MAX_CFG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] en_up,
    input  logic [NUM_SRC-1:0] en_dn,
    input  logic [MASK_W-1:0]  mask_lvl,
    output logic               irq_req,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);

    localparam int CW = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] fall_vec;
    logic [CW-1:0]      pend_cnt;
    vec_sel_t           sel_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        igq_src_track #(
            .GOV_CNT (MAX_CFG[ECNT_W*g +: ECNT_W])
        ) i_track (
            .clk    (clk),
            .rst    (rst),
            .lvl    (src_lvl[g]),
            .en_up  (en_up[g]),
            .en_dn  (en_dn[g]),
            .pend_q (pend_vec[g]),
            .rise   (rise_vec[g]),
            .fall   (fall_vec[g])
        );
    end

    igq_pend_count #(
        .NUM_SRC (NUM_SRC)
    ) i_count (
        .clk      (clk),
        .rst      (rst),
        .rise_vec (rise_vec),
        .fall_vec (fall_vec),
        .pend_cnt (pend_cnt),
        .irq_req  (irq_req)
    );

    igq_vec_pick #(
        .NUM_SRC  (NUM_SRC),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) i_pick (
        .clk      (clk),
        .rst      (rst),
        .pend_vec (pend_vec),
        .mask_lvl (mask_lvl),
        .sel_q    (sel_q)
    );

    assign vec_valid = sel_q.valid;
    assign vec_out   = sel_q.vec;

    // R6
    count_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        pend_cnt == CW'($countones(pend_vec)));

    // R6
    req_follows_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req == (pend_vec != '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_req && !vec_valid));

endmodule

// File: tb/test_irq_gate_agg.sv
module test_irq_gate_agg;
    import irq_gate_agg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam logic [VEC_W-1:0] BASE = 12'h200;
    localparam logic [VEC_W-1:0] STEP = 12'h020;

    typedef struct {
        string            tag;
        logic             irq;
        logic             valid;
        logic [VEC_W-1:0] vec;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N-1:0]     src_lvl = '0;
    logic [N-1:0]     en_up = '0;
    logic [N-1:0]     en_dn = '0;
    logic [3:0]       mask_lvl = 4'h0;
    logic             irq_req;
    logic             vec_valid;
    logic [VEC_W-1:0] vec_out;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   lvl_m[N];
    int   cnt_m[N];
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_gate_agg i_irq_gate_agg (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .en_up(en_up), .en_dn(en_dn),
        .mask_lvl(mask_lvl), .irq_req(irq_req), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    function automatic int gov(int i);
        return i % 4;
    endfunction

    function automatic bit pend_m(int i);
        return lvl_m[i] && (cnt_m[i] == gov(i));
    endfunction

    task automatic push(string tag, logic irq, logic valid, logic [VEC_W-1:0] vec);
        exp_t e;
        e.tag = tag; e.irq = irq; e.valid = valid; e.vec = vec;
        exp_q.push_back(e);
    endtask

    // Expected outputs from the bench model once everything has settled.
    task automatic settle_expect(string tag);
        bit any;
        logic [VEC_W-1:0] v;
        repeat (3) @(negedge clk);
        any = 0; v = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_m(i)) begin
                any = 1;
                v = BASE + VEC_W'(i) * STEP;
            end
        end
        push(tag, any, any && (mask_lvl != 4'hF), v);
    endtask

    task automatic set_lvl(int i, bit v);
        @(negedge clk);
        src_lvl[i] = v;
        lvl_m[i] = v;
    endtask

    task automatic pulse(int i, bit up, bit dn);
        @(negedge clk);
        en_up[i] = up;
        en_dn[i] = dn;
        if (up && !dn && cnt_m[i] < 3) cnt_m[i]++;
        if (dn && !up && cnt_m[i] > 0) cnt_m[i]--;
        @(negedge clk);
        en_up[i] = 1'b0;
        en_dn[i] = 1'b0;
    endtask

    task automatic set_mask(logic [3:0] m);
        @(negedge clk);
        mask_lvl = m;
    endtask

    // Monitor: compares queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                bit bad;
                e = exp_q.pop_front();
                checks++;
                bad = (irq_req !== e.irq) || (vec_valid !== e.valid) ||
                      (e.valid && vec_out !== e.vec);
                if (bad) begin
                    errors++;
                    $display("FAIL %s: actual irq=%0b valid=%0b vec=%h expected irq=%0b valid=%0b vec=%h",
                             e.tag, irq_req, vec_valid, vec_out, e.irq, e.valid, e.vec);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            lvl_m[i] = 0;
            cnt_m[i] = 0;
        end
        repeat (3) @(negedge clk);
        push("R1 during reset", 1'b0, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        push("R1 after reset", 1'b0, 1'b0, '0);

        // R9 / R5: source 0 has zero governors, pends on its line alone
        set_lvl(0, 1);
        @(negedge clk);
        push("R9 irq one edge after line", 1'b1, 1'b0, '0);
        @(negedge clk);
        push("R9 R5 vector two edges after line", 1'b1, 1'b1, BASE);

        // R2: same level repeated
        set_lvl(0, 1);
        set_lvl(0, 1);
        settle_expect("R2 repeated level no change");
        set_lvl(0, 0);
        settle_expect("R6 last clears drops irq");

        // R3: source 2 needs two enables
        set_lvl(2, 1);
        settle_expect("R5 line without enables not pending");
        pulse(2, 1, 0);
        settle_expect("R3 one of two enables not pending");
        pulse(2, 1, 1);
        settle_expect("R3 simultaneous up/down no change");
        pulse(2, 1, 0);
        settle_expect("R3 count reaches governor count");

        // R8: lower index wins, R6 hold while others pend
        pulse(1, 1, 0);
        set_lvl(1, 1);
        settle_expect("R8 lowest pending index wins");
        set_lvl(1, 0);
        settle_expect("R6 R8 irq holds vector moves");

        // R7: mask ceiling
        set_mask(4'hF);
        settle_expect("R7 mask ceiling withholds vector");
        set_mask(4'hE);
        settle_expect("R8 mask below ceiling restores vector");
        set_lvl(2, 0);

        // R4: top saturation on source 3 (three governors)
        set_lvl(3, 1);
        pulse(3, 1, 0);
        pulse(3, 1, 0);
        pulse(3, 1, 0);
        settle_expect("R3 three of three enables pending");
        pulse(3, 1, 0);
        pulse(3, 0, 1);
        settle_expect("R4 up at top ignored");
        set_lvl(3, 0);

        // R4: floor saturation on source 5 (one governor)
        set_lvl(5, 1);
        pulse(5, 0, 1);
        settle_expect("R4 down at zero ignored");
        pulse(5, 1, 0);
        settle_expect("R4 single up after floor enables");
        set_lvl(5, 0);
        settle_expect("R6 all clear irq low");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule